// File: doc/BRIEF.md
# Delayed Command Cluster Timer

This block schedules stored command clusters against a coarse time base. A cluster is described by one 16-bit word that carries a 14-bit delay, in steps of the time base, and a 2-bit command count. A prescaler divides the system clock down to one step pulse per time-base period; at the default setting, with a 125 MHz clock, one step is 8 seconds. A 14-bit delay therefore reaches about 36.4 hours.

Two independent countdown slots each hold one cluster. A load goes to whichever slot is idle, so the next cluster can count down while the consumer is still draining the commands of a cluster that is already due. The consumer sees the due cluster, pops its commands one per acknowledge, and the slot frees itself when the last command is taken. A load that finds both slots busy is refused and sets a sticky overflow flag.

Top module: `dly_cluster_timer`

## Requirements
- R1: `load_word[15:14]` holds the command count minus one (2'b00 = 1 command, 2'b11 = 4 commands) and `load_word[13:0]` holds the delay in steps. A load is accepted, with `load_accept` high in the same cycle as `load_valid`, exactly when at least one slot is idle. Slot 0 is used when both slots are idle.
- R2: `step_tick` is high for one cycle in every `TICKS_PER_STEP` cycles. Its first pulse is in the `TICKS_PER_STEP`-th cycle after reset is released.
- R3: A cluster loaded with delay d shows as due in the cycle after the (d+1)-th step pulse that follows its load cycle. A step pulse in the load cycle itself does not count, and a delay of 0 becomes due right after the next pulse.
- R4: A load offered while neither slot is idle is refused and leaves both slots unchanged. It sets `ovf_flag`, which stays high until reset.
- R5: `due_valid` is high whenever a slot holds a due cluster, and `due_slot` names that slot. When both slots are due and no drain is in progress, the slot loaded earlier is shown.
- R6: Each `cmd_ack` while `due_valid` is high advances `due_idx` from 0 up to count-1. `due_last` marks the final command. The acknowledge of the final command frees the slot, so it is idle and loadable in the next cycle.
- R7: Once the first command of a cluster has been acknowledged, `due_slot` stays on that cluster until its last command is acknowledged.
- R8: A `cmd_ack` while `due_valid` is low has no effect: the next cluster to become due starts at `due_idx` 0.
- R9: A slot keeps counting step pulses while the other slot is due or being drained.
- R10: After reset both slots are idle, `due_valid` and `ovf_flag` are low, and `due_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Offer a new cluster word |
| load_word | input | 16 | Count-minus-one in [15:14], delay in steps in [13:0] |
| load_accept | output | 1 | The offered cluster was taken into a slot |
| step_tick | output | 1 | One-cycle time-base step pulse |
| due_valid | output | 1 | A due cluster is being presented |
| due_slot | output | 1 | Slot that holds the presented cluster |
| due_idx | output | 2 | Index of the current command in the presented cluster |
| due_last | output | 1 | The current command is the cluster's last |
| cmd_ack | input | 1 | Consumer takes the current command |
| ovf_flag | output | 1 | Sticky: a load was refused |

## Verification
A slot stuck in its countdown, or one that skips a step, shows as `due_valid` rising one or more step periods early or late. This is visible at the ports within one step period of the expected release. A wrong age pointer or a drain lock that does not hold shows as `due_slot` naming the wrong slot on the first cycle in which both slots are due, or right after a mid-cluster acknowledge. A slot that is not freed shows as `load_accept` staying low on the next offered load. The bench compares every output in every cycle against a model built from the requirements, so each of these faults surfaces in the cycle it occurs.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int DLY_W  = 14;
  localparam int CNT_W  = 2;
  localparam int WORD_W = DLY_W + CNT_W;
  localparam int SLOTS  = 2;

  typedef logic [DLY_W-1:0]  dly_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_WAIT = 2'd1,
    SL_DUE  = 2'd2
  } slot_st_t;

  // count field sits above the delay bits
  function automatic cnt_t f_cnt_field(input word_t w);
    return w[WORD_W-1 -: CNT_W];
  endfunction

  function automatic dly_t f_dly_field(input word_t w);
    return w[DLY_W-1:0];
  endfunction

  // count is stored as number-of-commands minus one
  function automatic logic f_is_last(input cnt_t idx, input cnt_t cnt_m1);
    return idx == cnt_m1;
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  logic [PW-1:0] pc_q;

  assign tick = (pc_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= '0;
    else if (tick) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end

  generate
    if (TICKS > 1) begin : g_chk
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/dct_slot.sv
module dct_slot
  import dct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load_en,
  input  dly_t load_dly,
  input  cnt_t load_cnt,
  input  logic clear_en,
  output logic busy,
  output logic due,
  output cnt_t cnt
);
  slot_st_t st_q;
  dly_t     rem_q;
  cnt_t     cnt_q;
  logic     expire;

  assign expire = (st_q == SL_WAIT) && tick && (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SL_IDLE;
      rem_q <= '0;
      cnt_q <= '0;
    end else if (clear_en) begin
      st_q <= SL_IDLE;
    end else if (load_en) begin
      st_q  <= SL_WAIT;
      rem_q <= load_dly;
      cnt_q <= load_cnt;
    end else if (expire) begin
      st_q <= SL_DUE;
    end else if (st_q == SL_WAIT && tick) begin
      rem_q <= rem_q - dly_t'(1);
    end
  end

  assign busy = (st_q != SL_IDLE);
  assign due  = (st_q == SL_DUE);
  assign cnt  = cnt_q;

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (st_q == SL_IDLE)); // R1
  AST_CLEAR_ONLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |-> (st_q == SL_DUE)); // R6
  AST_DUE_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !clear_en) |=> due); // R6
endmodule

// File: rtl/dct_head.sv
module dct_head
  import dct_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            due_vec,
  input  logic [SLOTS-1:0][CNT_W-1:0] cnt_vec,
  input  logic                        old_ptr,
  input  logic                        cmd_ack,
  output logic                        head_valid,
  output logic                        head_sel,
  output cnt_t                        head_idx,
  output logic                        head_last,
  output logic [SLOTS-1:0]            clear_vec
);
  cnt_t idx_q;
  logic hold_q;
  logic draining;
  logic pick;
  logic pop;

  assign draining   = (idx_q != '0);
  // mid-cluster the held slot wins; otherwise the older due slot first
  assign pick       = draining ? hold_q : (due_vec[old_ptr] ? old_ptr : ~old_ptr);
  assign head_valid = due_vec[pick];
  assign head_last  = head_valid && f_is_last(idx_q, cnt_vec[pick]);
  assign pop        = head_valid && cmd_ack;
  assign head_sel   = pick;
  assign head_idx   = idx_q;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_clr
      assign clear_vec[g] = pop && head_last && (pick == 1'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hold_q <= 1'b0;
    end else if (pop) begin
      idx_q  <= head_last ? '0 : idx_q + 1'b1;
      hold_q <= pick;
    end
  end

  AST_DRAIN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && cmd_ack && !head_last) |=>
      (head_valid && head_sel == $past(head_sel) && head_idx == cnt_t'($past(head_idx) + 1'b1))); // R7
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_valid && cmd_ack) |=> $stable(idx_q)); // R8
endmodule

// File: rtl/dly_cluster_timer.sv
module dly_cluster_timer
  import dct_pkg::*;
#(
  parameter int unsigned TICKS_PER_STEP = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_word,
  output logic              load_accept,
  output logic              step_tick,
  output logic              due_valid,
  output logic              due_slot,
  output logic [CNT_W-1:0]  due_idx,
  output logic              due_last,
  input  logic              cmd_ack,
  output logic              ovf_flag
);
  logic                        tick;
  logic [SLOTS-1:0]            busy_vec;
  logic [SLOTS-1:0]            due_vec;
  logic [SLOTS-1:0][CNT_W-1:0] cnt_vec;
  logic [SLOTS-1:0]            load_vec;
  logic [SLOTS-1:0]            clear_vec;
  logic [SLOTS-1:0]            busy_next;
  logic                        any_idle;
  logic                        alloc_sel;
  logic                        refuse;
  logic                        old_q;
  logic                        ovf_q;

  dct_prescaler #(.TICKS(TICKS_PER_STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign any_idle    = ~&busy_vec;
  assign alloc_sel   = busy_vec[0];
  assign load_accept = load_valid && any_idle;
  assign refuse      = load_valid && !any_idle;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_slot
      assign load_vec[g]  = load_accept && (alloc_sel == 1'(g));
      assign busy_next[g] = (busy_vec[g] && !clear_vec[g]) || load_vec[g];
      dct_slot u_slot (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load_en(load_vec[g]),
        .load_dly(f_dly_field(load_word)),
        .load_cnt(f_cnt_field(load_word)),
        .clear_en(clear_vec[g]),
        .busy(busy_vec[g]), .due(due_vec[g]), .cnt(cnt_vec[g])
      );
    end
  endgenerate

  dct_head u_head (
    .clk(clk), .rst_n(rst_n),
    .due_vec(due_vec), .cnt_vec(cnt_vec), .old_ptr(old_q),
    .cmd_ack(cmd_ack),
    .head_valid(due_valid), .head_sel(due_slot), .head_idx(due_idx),
    .head_last(due_last), .clear_vec(clear_vec)
  );

  // age pointer: the slot that has been holding its cluster longer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (load_accept)
        old_q <= busy_next[~alloc_sel] ? ~alloc_sel : alloc_sel;
      else if (clear_vec[0])
        old_q <= 1'b1;
      else if (clear_vec[1])
        old_q <= 1'b0;
      if (refuse) ovf_q <= 1'b1;
    end
  end

  assign step_tick = tick;
  assign ovf_flag  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R4
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(load_valid)); // R4
  AST_REFUSE_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !due_valid) |=> (busy_vec == 2'b11)); // R4
endmodule

// File: tb/dly_cluster_timer_tb_top.sv
module dly_cluster_timer_tb_top;
  localparam int unsigned T = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_valid;
  logic [15:0] load_word;
  logic        load_accept;
  logic        step_tick;
  logic        due_valid;
  logic        due_slot;
  logic [1:0]  due_idx;
  logic        due_last;
  logic        cmd_ack;
  logic        ovf_flag;

  always #4 clk = ~clk;

  dly_cluster_timer #(.TICKS_PER_STEP(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
    .load_accept(load_accept), .step_tick(step_tick), .due_valid(due_valid),
    .due_slot(due_slot), .due_idx(due_idx), .due_last(due_last),
    .cmd_ack(cmd_ack), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: 0 idle, 1 counting, 2 due
  int m_pc, m_old, m_idx, m_hold;
  int m_st[2];
  int m_rem[2];
  int m_ncmd[2];
  bit m_ovf;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cmds_in(input logic [15:0] w);
    return int'(w[15:14]) + 1;
  endfunction

  task automatic model_init();
    m_pc = 0; m_old = 0; m_idx = 0; m_hold = 0; m_ovf = 0;
    for (int k = 0; k < 2; k++) begin m_st[k] = 0; m_rem[k] = 0; m_ncmd[k] = 1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load_valid = 1'b0; load_word = '0; cmd_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_init();
  endtask

  // one cycle: drive at the falling edge, compare, advance the model
  task automatic step(input bit lv, input logic [15:0] w, input bit ack);
    bit tick, acc, valid, last;
    int tgt, sel, clr;
    load_valid = lv; load_word = w; cmd_ack = ack;
    #1;
    tick  = (m_pc == T - 1);
    acc   = lv && (m_st[0] == 0 || m_st[1] == 0);
    tgt   = (m_st[0] == 0) ? 0 : 1;
    sel   = (m_idx != 0) ? m_hold : ((m_st[m_old] == 2) ? m_old : 1 - m_old);
    valid = (m_st[sel] == 2);
    last  = valid && (m_idx == m_ncmd[sel] - 1);
    chk("R2 step_tick", step_tick, tick);
    chk("R1 load_accept", load_accept, acc);
    chk("R3 R5 R9 due_valid", due_valid, valid);
    if (valid) begin
      chk("R5 R7 due_slot", due_slot, sel);
      chk("R6 R8 due_idx", due_idx, m_idx);
      chk("R6 due_last", due_last, last);
    end
    chk("R4 ovf_flag", ovf_flag, m_ovf);
    clr = -1;
    if (valid && ack) begin
      m_hold = sel;
      if (last) begin clr = sel; m_idx = 0; end
      else m_idx++;
    end
    for (int k = 0; k < 2; k++) begin
      if (k == clr) m_st[k] = 0;
      else if (acc && k == tgt) begin
        m_st[k] = 1; m_rem[k] = int'(w[13:0]); m_ncmd[k] = cmds_in(w);
      end else if (m_st[k] == 1 && tick) begin
        if (m_rem[k] == 0) m_st[k] = 2;
        else m_rem[k]--;
      end
    end
    if (acc) m_old = (m_st[1 - tgt] != 0) ? 1 - tgt : tgt;
    else if (clr >= 0) m_old = 1 - clr;
    if (lv && !acc) m_ovf = 1;
    m_pc = tick ? 0 : m_pc + 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit ack);
    for (int i = 0; i < n; i++) step(0, '0, ack);
  endtask

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    do_reset();
    // R10: reset state
    chk("R10 due_valid", due_valid, 0);
    chk("R10 ovf_flag", ovf_flag, 0);
    chk("R10 due_idx", due_idx, 0);

    // R3: delay 0 with four commands, released after the first step pulse
    step(1, {2'b11, 14'd0}, 0);
    idle(T + 1, 0);
    chk("R3 delay0 due", due_valid, 1);
    chk("R1 slot0 first", due_slot, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1);   // R6 drain of four
    chk("R6 freed", due_valid, 0);

    // R8: acknowledges with nothing due
    idle(5, 1);
    chk("R8 idx unchanged", due_idx, 0);

    // R4 R9: fill both slots, refuse a third, drain one while the other counts
    step(1, {2'b01, 14'd20}, 0);
    step(1, {2'b00, 14'd3}, 0);
    step(1, {2'b10, 14'd1}, 0);
    chk("R4 ovf set", ovf_flag, 1);
    idle(4 * T + 4, 0);
    chk("R9 slot1 due first", due_slot, 1);
    idle(120, 1);
    chk("R4 ovf still set", ovf_flag, 1);

    // R5: both due at once, older slot shown first
    do_reset();
    step(1, {2'b01, 14'd2}, 0);
    step(1, {2'b01, 14'd0}, 0);
    idle(4 * T, 0);
    chk("R5 oldest first", due_slot, 0);
    step(0, '0, 1);
    idle(2, 0);
    chk("R7 lock held", due_slot, 0);
    idle(6, 1);

    // random traffic
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit lv, ak;
      logic [15:0] w;
      lv = ($urandom % 6) == 0;
      ak = ($urandom % 2) == 0;
      w  = {2'($urandom % 4), 14'($urandom % 8)};
      step(lv, w, ak);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in R6 drain sequencing actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule